// File: doc/BRIEF.md
# Overdrive 1-Wire Slave Bit Engine

This block is the bit-level front end of a 1-Wire slave that only runs at overdrive speed. It watches the open-drain bus through a synchronized input and pulls the bus low through a single output. It turns master activity on the bus into three kinds of event:

- A long low is reported as a bus reset, and the block answers it with a presence pulse.
- A short low followed by a high line at the sample point is reported as a received one.
- A low that lasts past the sample point is reported as a received zero.

In slots where the layer above wants to send a zero, the block holds the line low past the master's sampling point.

The layer above sees four signals: a one-cycle reset strobe, a one-cycle bit strobe with its bit value, a direction flag and a transmit bit. The direction flag and the transmit bit are captured at the falling edge of each slot. In a transmit slot the bit strobe reports the level that was sampled on the wired-AND line, so a protocol layer can also use it for arbitration. All timing comes from one cycle counter. Its thresholds are derived from a clock-frequency parameter and from a set of microsecond parameters.

Top module: `ow_od_slot_engine`

## Requirements
- R1: After reset the pull-low output is inactive and neither strobe fires until the master starts bus activity.
- R2: A low lasting 40 µs or more produces exactly one reset strobe when the line returns high, and no bit strobe.
- R3: After a reset strobe the block pulls the line low from about 2 µs to about 12 µs after the release. The line reads 0 at 8 µs and 10 µs after release and reads 1 again by 14 µs.
- R4: Falling edges during the 48 µs after a reset release produce no bit strobe.
- R5: A slot in which the line is high again 5 µs after the falling edge yields one bit strobe with value 1.
- R6: A slot whose low lasts from 5 µs to 16 µs yields one bit strobe with value 0 when the line is released.
- R7: A low that lasts longer than 16 µs but shorter than 40 µs yields neither a bit strobe nor a reset strobe.
- R8: With the direction flag set to 1 (slave sends) and the transmit bit at 0, the block pulls the line low from the falling edge until 6 µs after it, and the bit strobe reports 0.
- R9: With the direction flag at 1 and the transmit bit at 1, the block never pulls the line, and the bit strobe reports 1.
- R10: A high pulse of a single clock cycle inside a low period is ignored. The slot yields exactly one bit strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw bus level (1 = released, 0 = low) |
| pull_o | output | 1 | 1 = drive the bus low |
| bus_rst_o | output | 1 | One-cycle strobe: bus reset detected |
| bit_stb_o | output | 1 | One-cycle strobe: slot finished |
| bit_val_o | output | 1 | Bit value sampled in the last slot |
| tx_dir_i | input | 1 | 1 = slave sends in the next slot, 0 = slave receives |
| tx_bit_i | input | 1 | Bit to send when tx_dir_i is 1 |

## Verification
Two functions can coincide: the end of the post-reset lockout, and the acceptance of a new falling edge. A master slot that arrives just before lockout expiry must be ignored, while one shortly after must be taken. The bench provokes this by placing a short low at 44 µs after a reset release and another at 52 µs. It expects no strobe for the first and a value-1 strobe for the second.

The same boundary reasoning applies inside a slot, where the sample point and the release of the slave's own pull-low follow each other within one microsecond. For that case the bench reads the bus level between the two points and again after both.

// File: rtl/ow_od_pkg.sv
package ow_od_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RECOV
  } slot_st_e;

  // microseconds to clock cycles without 32-bit overflow
  function automatic int us_to_cyc(input int clk_hz, input int us);
    return ((clk_hz / 1000) * us) / 1000;
  endfunction

endpackage

// File: rtl/ow_od_line_filter.sv
module ow_od_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);

  localparam int HW = $clog2(MIN_HIGH + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hi_q, hi_n;
  logic                   level_q, level_n;
  logic                   fall_q;
  logic                   sync_top;

  assign sync_top = sync_q[SYNC_STAGES-1];

  always_comb begin
    hi_n    = hi_q;
    level_n = level_q;
    if (!sync_top) begin
      hi_n    = '0;
      level_n = 1'b0;
    end else begin
      if (hi_q != HW'(MIN_HIGH)) hi_n = hi_q + HW'(1);
      if (hi_n == HW'(MIN_HIGH)) level_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '1;
      hi_q    <= HW'(MIN_HIGH);
      level_q <= 1'b1;
      fall_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], line_i};
      hi_q    <= hi_n;
      level_q <= level_n;
      fall_q  <= level_q & ~level_n;
    end
  end

  assign level_o = level_q;
  assign fall_o  = fall_q;

  // R10: a synchronized low forces the filtered level low on the next cycle
  a_r10_low_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_top |=> !level_q);

  // R10: the filtered level only rises after a synchronized high
  a_r10_rise_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_q) |-> $past(sync_top));

  // R5: a fall strobe marks a high-to-low step of the filtered level
  a_r5_fall_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q |-> (!level_q && $past(level_q)));

endmodule

// File: rtl/ow_od_slot_ctrl.sv
module ow_od_slot_ctrl
  import ow_od_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int SAMPLE_US    = 5,
  parameter int HOLD_US      = 6,
  parameter int VALID_MAX_US = 16,
  parameter int RESET_MIN_US = 40,
  parameter int PRES_ON_US   = 2,
  parameter int PRES_OFF_US  = 12,
  parameter int LOCK_US      = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic fall_i,
  input  logic tx_dir_i,
  input  logic tx_bit_i,
  output logic pull_o,
  output logic rst_stb_o,
  output logic rx_stb_o,
  output logic rx_bit_o
);

  localparam int T_SAMPLE = us_to_cyc(CLK_HZ, SAMPLE_US);
  localparam int T_HOLD   = us_to_cyc(CLK_HZ, HOLD_US);
  localparam int T_VMAX   = us_to_cyc(CLK_HZ, VALID_MAX_US);
  localparam int T_RST    = us_to_cyc(CLK_HZ, RESET_MIN_US);
  localparam int T_PON    = us_to_cyc(CLK_HZ, PRES_ON_US);
  localparam int T_POFF   = us_to_cyc(CLK_HZ, PRES_OFF_US);
  localparam int T_LOCK   = us_to_cyc(CLK_HZ, LOCK_US);
  localparam int T_MAX_A  = (T_LOCK > T_RST) ? T_LOCK : T_RST;
  localparam int T_MAX    = (T_MAX_A > T_POFF) ? T_MAX_A : T_POFF;
  localparam int CNT_W    = $clog2(T_MAX + 1);

  localparam logic [CNT_W-1:0] C_SAMPLE = CNT_W'(T_SAMPLE);
  localparam logic [CNT_W-1:0] C_HOLD   = CNT_W'(T_HOLD);
  localparam logic [CNT_W-1:0] C_VMAX   = CNT_W'(T_VMAX);
  localparam logic [CNT_W-1:0] C_RST    = CNT_W'(T_RST);
  localparam logic [CNT_W-1:0] C_PON    = CNT_W'(T_PON);
  localparam logic [CNT_W-1:0] C_POFF   = CNT_W'(T_POFF);
  localparam logic [CNT_W-1:0] C_LOCK   = CNT_W'(T_LOCK);
  localparam logic [CNT_W-1:0] C_MAX    = CNT_W'(T_MAX);

  slot_st_e         st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_clr;
  logic             smp_q, smp_n;
  logic             drv0_q, drv0_n;
  logic             pull_q, pull_n;
  logic             rx_stb_q, rx_stb_n;
  logic             rx_bit_q, rx_bit_n;
  logic             rst_stb_q, rst_stb_n;

  always_comb begin
    st_n      = st_q;
    cnt_clr   = 1'b0;
    smp_n     = smp_q;
    drv0_n    = drv0_q;
    rx_stb_n  = 1'b0;
    rx_bit_n  = rx_bit_q;
    rst_stb_n = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (fall_i) begin
          st_n    = ST_SLOT;
          cnt_clr = 1'b1;
          smp_n   = 1'b0;
          drv0_n  = tx_dir_i & ~tx_bit_i;
        end
      end
      ST_SLOT: begin
        if (!smp_q) begin
          if (cnt_q == C_SAMPLE) begin
            smp_n = 1'b1;
            if (level_i) begin
              rx_stb_n = 1'b1;
              rx_bit_n = 1'b1;
              st_n     = ST_IDLE;
            end
          end
        end else if (level_i) begin
          if (cnt_q <= C_VMAX) begin
            rx_stb_n = 1'b1;
            rx_bit_n = 1'b0;
            st_n     = ST_IDLE;
          end else if (cnt_q >= C_RST) begin
            rst_stb_n = 1'b1;
            st_n      = ST_RECOV;
            cnt_clr   = 1'b1;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_RECOV: begin
        if (cnt_q == C_LOCK) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase

    if (cnt_clr)             cnt_n = '0;
    else if (cnt_q == C_MAX) cnt_n = cnt_q;
    else                     cnt_n = cnt_q + CNT_W'(1);

    pull_n = ((st_n == ST_SLOT) && drv0_n && (cnt_n < C_HOLD)) ||
             ((st_n == ST_RECOV) && (cnt_n >= C_PON) && (cnt_n < C_POFF));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      smp_q     <= 1'b0;
      drv0_q    <= 1'b0;
      pull_q    <= 1'b0;
      rx_stb_q  <= 1'b0;
      rx_bit_q  <= 1'b0;
      rst_stb_q <= 1'b0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      smp_q     <= smp_n;
      drv0_q    <= drv0_n;
      pull_q    <= pull_n;
      rx_stb_q  <= rx_stb_n;
      rx_bit_q  <= rx_bit_n;
      rst_stb_q <= rst_stb_n;
    end
  end

  assign pull_o    = pull_q;
  assign rst_stb_o = rst_stb_q;
  assign rx_stb_o  = rx_stb_q;
  assign rx_bit_o  = rx_bit_q;

  // R5: a bit strobe lasts a single cycle
  a_r5_strobe_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stb_q |=> !rx_stb_q);

  // R2: a reset never doubles as a data bit
  a_r2_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_stb_q |-> !rx_stb_q);

  // R3: the presence pull-low starts after the reset strobe, not with it
  a_r3_presence_delayed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_stb_q |-> !pull_q);

  // R4: no bit is reported while the post-reset lockout runs
  a_r4_lock_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RECOV) |-> !rx_stb_q);

  // R8: the line is only pulled inside a slot or the recovery window
  a_r8_pull_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_q |-> (st_q != ST_IDLE));

endmodule

// File: rtl/ow_od_slot_engine.sv
module ow_od_slot_engine #(
  parameter int CLK_HZ       = 50_000_000,
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_HIGH     = 2,
  parameter int SAMPLE_US    = 5,
  parameter int HOLD_US      = 6,
  parameter int VALID_MAX_US = 16,
  parameter int RESET_MIN_US = 40,
  parameter int PRES_ON_US   = 2,
  parameter int PRES_OFF_US  = 12,
  parameter int LOCK_US      = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic pull_o,
  output logic bus_rst_o,
  output logic bit_stb_o,
  output logic bit_val_o,
  input  logic tx_dir_i,
  input  logic tx_bit_i
);

  logic level;
  logic fall;

  ow_od_line_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_HIGH    (MIN_HIGH)
  ) u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .level_o (level),
    .fall_o  (fall)
  );

  ow_od_slot_ctrl #(
    .CLK_HZ       (CLK_HZ),
    .SAMPLE_US    (SAMPLE_US),
    .HOLD_US      (HOLD_US),
    .VALID_MAX_US (VALID_MAX_US),
    .RESET_MIN_US (RESET_MIN_US),
    .PRES_ON_US   (PRES_ON_US),
    .PRES_OFF_US  (PRES_OFF_US),
    .LOCK_US      (LOCK_US)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level),
    .fall_i    (fall),
    .tx_dir_i  (tx_dir_i),
    .tx_bit_i  (tx_bit_i),
    .pull_o    (pull_o),
    .rst_stb_o (bus_rst_o),
    .rx_stb_o  (bit_stb_o),
    .rx_bit_o  (bit_val_o)
  );

endmodule

// File: tb/ow_od_slot_engine_bench.sv
module ow_od_slot_engine_bench;

  localparam int US = 50;  // cycles per microsecond at 50 MHz

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic m_low;
  logic tx_dir;
  logic tx_bit;
  logic pull;
  logic bus;
  logic bus_rst;
  logic bit_stb;
  logic bit_val;

  assign bus = ~(m_low | pull);

  ow_od_slot_engine u_ow_od_slot_engine (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .line_i    (bus),
    .pull_o    (pull),
    .bus_rst_o (bus_rst),
    .bit_stb_o (bit_stb),
    .bit_val_o (bit_val),
    .tx_dir_i  (tx_dir),
    .tx_bit_i  (tx_bit)
  );

  int   n_vec = 0;
  int   n_bad = 0;
  int   rx_cnt = 0;
  int   rst_cnt = 0;
  logic last_bit = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) begin
    if (rst_n === 1'b1) begin
      if (bit_stb) begin
        rx_cnt   = rx_cnt + 1;
        last_bit = bit_val;
      end
      if (bus_rst) rst_cnt = rst_cnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_for(input int n);
    m_low = 1'b1;
    wait_cyc(n);
    m_low = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1 pull idle", int'(pull), 0);
    check("R1 bus high", int'(bus), 1);
    check("R1 no bit strobe", rx_cnt, 0);
    check("R1 no reset strobe", rst_cnt, 0);
  endtask

  task automatic t_bus_reset();
    int r0 = rst_cnt;
    int b0 = rx_cnt;
    low_for(50 * US);
    wait_cyc(425);
    check("R3 presence at 8.5us", int'(bus), 0);
    wait_cyc(50);
    check("R3 presence at 9.5us", int'(bus), 0);
    check("R2 one reset strobe", rst_cnt, r0 + 1);
    check("R2 no bit strobe", rx_cnt, b0);
    wait_cyc(225);
    check("R3 released by 14us", int'(bus), 1);
    wait_cyc(300);
    low_for(US);
    wait_cyc(500);
    check("R4 slot in lockout ignored", rx_cnt, b0);
    wait_cyc(1500);
  endtask

  task automatic t_write(input string req, input int low_cyc, input int exp);
    int b0 = rx_cnt;
    low_for(low_cyc);
    wait_cyc(12 * US);
    check(req, rx_cnt, b0 + 1);
    check(req, int'(last_bit), exp);
  endtask

  task automatic t_long_low();
    int b0 = rx_cnt;
    int r0 = rst_cnt;
    low_for(25 * US);
    wait_cyc(12 * US);
    check("R7 no bit strobe", rx_cnt, b0);
    check("R7 no reset strobe", rst_cnt, r0);
  endtask

  task automatic t_tx(input string req, input logic b);
    int b0 = rx_cnt;
    tx_dir = 1'b1;
    tx_bit = b;
    low_for(US);
    wait_cyc(225);
    check(req, int'(bus), int'(b));
    wait_cyc(125);
    check(req, int'(bus), 1);
    wait_cyc(400);
    check(req, rx_cnt, b0 + 1);
    check(req, int'(last_bit), int'(b));
    tx_dir = 1'b0;
    tx_bit = 1'b0;
  endtask

  task automatic t_glitch();
    int b0 = rx_cnt;
    low_for(7 * US);
    wait_cyc(1);
    low_for(3 * US - 1);
    wait_cyc(12 * US);
    check("R10 single strobe", rx_cnt, b0 + 1);
    check("R10 value zero", int'(last_bit), 0);
  endtask

  task automatic t_lock_edge();
    int b0;
    int r0 = rst_cnt;
    low_for(50 * US);
    wait_cyc(44 * US);
    b0 = rx_cnt;
    low_for(US);
    wait_cyc(7 * US);
    check("R4 slot at 44us ignored", rx_cnt, b0);
    check("R2 reset counted", rst_cnt, r0 + 1);
    low_for(US);
    wait_cyc(12 * US);
    check("R5 slot at 52us taken", rx_cnt, b0 + 1);
    check("R5 slot at 52us value", int'(last_bit), 1);
  endtask

  initial begin
    rst_n  = 1'b0;
    m_low  = 1'b0;
    tx_dir = 1'b0;
    tx_bit = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(20);
    t_reset_state();
    t_bus_reset();
    t_write("R5 write-one 1us", US, 1);
    t_write("R5 write-one 0.5us", US / 2, 1);
    t_write("R6 write-zero 10us", 10 * US, 0);
    t_write("R6 write-zero 15us", 15 * US, 0);
    t_long_low();
    t_tx("R8 send zero", 1'b0);
    t_tx("R9 send one", 1'b1);
    t_glitch();
    t_lock_edge();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule